// File: doc/BRIEF.md
# Single-wire bus bit-slot timing master

This block produces the four primitive operations of a single-wire open-drain bus: a reset pulse followed by presence sensing, a write-one slot, a write-zero slot and a read slot. It runs from a one-microsecond tick. It drives the shared line through a drive-low enable, and it reads the line back through a sampled input. A caller starts one operation at a time with a start pulse, an operation code and a speed select. The caller then waits for a one-cycle done pulse. The read bit or the presence result remains on the outputs until the next operation starts.

Two timing sets are held in registers, one for regular speed and one for overdrive. Each set has eleven microsecond parameters and loads its defaults at reset. A configuration write goes through only when the value lies inside the legal window of that parameter. Otherwise the stored value is kept and an error flag is raised. The sample point for read data has an empty window, so no write can ever move it. The block snapshots the chosen set when an operation starts, so the caller can pick the speed for each operation. Grouping bits into bytes and addressing devices are left to the logic above this block.

Top module: `owb_slot_master`

## Requirements
- R1: After reset, busy, done, drive_low, bit_out, cfg_err and pres are all 0. The configuration readback shows the defaults. Regular speed: slot 60, zero-low 60, one-low 1, release 45, recovery 15, sample 15, reset-low 480, reset-high 480, presence-low 60, presence-high 60, read-low 1. Overdrive: 11, 6, 1, 4, 1, 2, 48, 48, 8, 2, 1.
- R2: Parameter select codes are slot=0, zero-low=1, one-low=2, release=3, recovery=4, sample=5, reset-low=6, reset-high=7, presence-low=8, presence-high=9, read-low=10. cfg_speed is 0 for regular and 1 for overdrive. A write is stored only if lo <= value < hi. The windows are: regular slot [60,120), one-low [1,15), presence-low [60,240), release [0,45); overdrive slot [6,16), reset-low [48,80). On each write, cfg_err becomes 1 on rejection and 0 on acceptance. A rejected write, including one with a select of 11 or more, leaves the stored value unchanged. Readback of a select of 11 or more returns 0.
- R3: The read-data sample point stays 15 at regular speed and 2 at overdrive, because every write to select 5 is rejected.
- R4: Recovery has no upper bound in principle and uses 960 as its upper limit, so 959 is accepted and 960 is rejected.
- R5: Op codes are 0 reset, 1 write-zero, 2 write-one and 3 read. A write slot drives the line low for its low time in ticks, then releases it. Done pulses slot+recovery ticks after the clock edge that takes start.
- R6: A read slot drives low for read-low ticks and samples the line when the slot count equals the sample time. bit_out returns the sampled level. Done comes slot+recovery ticks after start.
- R7: A reset drives low for reset-low ticks, then releases for reset-high ticks. Done comes reset-low+reset-high+recovery ticks after start. The presence window runs from presence-high to presence-high+presence-low ticks after release. pres is 0 if a low was seen inside the window, 1 if no low was seen, and 2 if the line is still low at the end of reset-high.
- R8: Each operation uses the timing set chosen by speed at start, including values written earlier through configuration.
- R9: A start while busy is ignored. done is a single-cycle pulse and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-microsecond timing tick |
| cfg_we | input | 1 | Timing parameter write strobe |
| cfg_speed | input | 1 | Set selected for write and readback (1 = overdrive) |
| cfg_sel | input | 4 | Parameter select |
| cfg_val | input | 10 | Value to write, in microseconds |
| cfg_rd | output | 10 | Readback of the selected parameter |
| cfg_err | output | 1 | Last write was rejected |
| start | input | 1 | Start an operation |
| op | input | 2 | Operation code |
| speed | input | 1 | Timing set for this operation (1 = overdrive) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_out | output | 1 | Bit sampled by the last read slot |
| pres | output | 2 | Result of the last reset |
| drive_low | output | 1 | Pull the bus line low |
| bus_in | input | 1 | Sampled bus line level |

## Verification
The bench holds the tick high, so one tick lasts one clock. It counts falling clock edges from the edge that takes start. Done must show up at exactly slot+recovery counts for slots, or reset-low+reset-high+recovery counts for reset. That gives 75 and 12 counts for regular and overdrive slots, and 975 and 97 counts for resets. The count of falling edges with drive_low high must match the programmed low time. A configuration write is checked at the falling edge after the edge that stores it, where cfg_err and cfg_rd have settled. The read bit and presence code are compared when done is seen. A bus model lets the bench pull the line low in chosen windows after release.

// File: rtl/owb_pkg.sv
package owb_pkg;

    localparam int TW     = 10;
    localparam int NPAR   = 11;
    localparam int NSPEED = 2;
    localparam int UNBND  = 960;

    typedef logic [TW-1:0] tval_t;
    typedef logic [NPAR-1:0][TW-1:0] tarr_t;

    typedef enum logic [3:0] {
        P_SLOT, P_LOW0, P_LOW1, P_REL, P_REC, P_RDV,
        P_RSTL, P_RSTH, P_PDL, P_PDH, P_LOWR
    } par_e;

    typedef enum logic [1:0] { OP_RESET, OP_WR0, OP_WR1, OP_READ } op_e;
    typedef enum logic [1:0] { PR_FOUND, PR_NONE, PR_SHORT } pres_e;
    typedef enum logic [2:0] { S_IDLE, S_RLOW, S_RHIGH, S_SLOT, S_REC } st_e;

    function automatic tval_t dflt(input logic od, input logic [3:0] idx);
        case (idx)
            P_SLOT: return od ? tval_t'(11) : tval_t'(60);
            P_LOW0: return od ? tval_t'(6)  : tval_t'(60);
            P_LOW1: return tval_t'(1);
            P_REL:  return od ? tval_t'(4)  : tval_t'(45);
            P_REC:  return od ? tval_t'(1)  : tval_t'(15);
            P_RDV:  return od ? tval_t'(2)  : tval_t'(15);
            P_RSTL: return od ? tval_t'(48) : tval_t'(480);
            P_RSTH: return od ? tval_t'(48) : tval_t'(480);
            P_PDL:  return od ? tval_t'(8)  : tval_t'(60);
            P_PDH:  return od ? tval_t'(2)  : tval_t'(60);
            P_LOWR: return tval_t'(1);
            default: return '0;
        endcase
    endfunction

    function automatic tval_t lo_lim(input logic od, input logic [3:0] idx);
        case (idx)
            P_SLOT, P_LOW0: return od ? tval_t'(6) : tval_t'(60);
            P_LOW1, P_REC, P_LOWR: return tval_t'(1);
            P_REL:  return '0;
            P_RDV:  return od ? tval_t'(2)  : tval_t'(15);
            P_RSTL, P_RSTH: return od ? tval_t'(48) : tval_t'(480);
            P_PDL:  return od ? tval_t'(8)  : tval_t'(60);
            P_PDH:  return od ? tval_t'(2)  : tval_t'(15);
            default: return '0;
        endcase
    endfunction

    function automatic tval_t hi_lim(input logic od, input logic [3:0] idx);
        case (idx)
            P_SLOT, P_LOW0: return od ? tval_t'(16) : tval_t'(120);
            P_LOW1, P_LOWR: return od ? tval_t'(2)  : tval_t'(15);
            P_REL:  return od ? tval_t'(4)  : tval_t'(45);
            P_REC, P_RSTH: return tval_t'(UNBND);
            P_RDV:  return od ? tval_t'(2)  : tval_t'(15);
            P_RSTL: return od ? tval_t'(80) : tval_t'(UNBND);
            P_PDL:  return od ? tval_t'(24) : tval_t'(240);
            P_PDH:  return od ? tval_t'(6)  : tval_t'(60);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/owb_timing_regs.sv
module owb_timing_regs
    import owb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       spd,
    input  logic [3:0] sel,
    input  tval_t      val,
    output tval_t      rd,
    output logic       err,
    output tarr_t      set_reg,
    output tarr_t      set_od
);
    logic [NSPEED-1:0][NPAR-1:0][TW-1:0] regs_q;
    logic ok;

    assign ok = (sel < 4'(NPAR)) && (val >= lo_lim(spd, sel)) && (val < hi_lim(spd, sel));

    for (genvar s = 0; s < NSPEED; s++) begin : g_spd
        for (genvar p = 0; p < NPAR; p++) begin : g_par
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[s][p] <= dflt(s == 1, 4'(p));
                else if (we && ok && (spd == (s == 1)) && (sel == 4'(p)))
                    regs_q[s][p] <= val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     err <= 1'b0;
        else if (we) err <= !ok;
    end

    always_comb begin
        rd = '0;
        for (int p = 0; p < NPAR; p++)
            if (sel == 4'(p)) rd = regs_q[spd][p];
    end

    assign set_reg = regs_q[0];
    assign set_od  = regs_q[1];

    assert_reject_hold_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (err |-> (regs_q == $past(regs_q))));
    assert_rdv_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (regs_q[0][P_RDV] == tval_t'(15)) && (regs_q[1][P_RDV] == tval_t'(2)));
    assert_rec_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (regs_q[0][P_REC] < tval_t'(UNBND)) && (regs_q[1][P_REC] < tval_t'(UNBND)));
endmodule

// File: rtl/owb_slot_fsm.sv
module owb_slot_fsm
    import owb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [1:0] op_i,
    input  logic       spd_i,
    input  tarr_t      set_reg,
    input  tarr_t      set_od,
    input  logic       bus_in,
    output logic       busy,
    output logic       done,
    output logic       bit_q,
    output logic [1:0] pres,
    output logic       drive_low
);
    st_e   st_q;
    op_e   op_q;
    tarr_t t_q;
    tval_t cnt_q, cnt_nx, low_t;
    logic  seen_q, in_win, win_low;

    assign cnt_nx  = cnt_q + 1'b1;
    assign in_win  = (cnt_q >= t_q[P_PDH]) && (cnt_q < t_q[P_PDH] + t_q[P_PDL]);
    assign win_low = in_win && !bus_in;
    assign busy    = (st_q != S_IDLE);

    always_comb begin
        case (op_q)
            OP_WR0:  low_t = t_q[P_LOW0];
            OP_WR1:  low_t = t_q[P_LOW1];
            default: low_t = t_q[P_LOWR];
        endcase
        case (st_q)
            S_RLOW:  drive_low = 1'b1;
            S_SLOT:  drive_low = (cnt_q < low_t);
            default: drive_low = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            op_q   <= OP_RESET;
            t_q    <= '0;
            cnt_q  <= '0;
            seen_q <= 1'b0;
            done   <= 1'b0;
            bit_q  <= 1'b0;
            pres   <= PR_FOUND;
        end else begin
            done <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    op_q   <= op_e'(op_i);
                    t_q    <= spd_i ? set_od : set_reg;
                    cnt_q  <= '0;
                    seen_q <= 1'b0;
                    st_q   <= (op_e'(op_i) == OP_RESET) ? S_RLOW : S_SLOT;
                end
                S_RLOW: if (tick) begin
                    if (cnt_nx == t_q[P_RSTL]) begin
                        cnt_q <= '0;
                        st_q  <= S_RHIGH;
                    end else cnt_q <= cnt_nx;
                end
                S_RHIGH: if (tick) begin
                    if (win_low) seen_q <= 1'b1;
                    if (cnt_nx == t_q[P_RSTH]) begin
                        if (!bus_in)                 pres <= PR_SHORT;
                        else if (seen_q || win_low)  pres <= PR_FOUND;
                        else                         pres <= PR_NONE;
                        cnt_q <= '0;
                        st_q  <= S_REC;
                    end else cnt_q <= cnt_nx;
                end
                S_SLOT: if (tick) begin
                    if (op_q == OP_READ && cnt_q == t_q[P_RDV]) bit_q <= bus_in;
                    if (cnt_nx == t_q[P_SLOT]) begin
                        cnt_q <= '0;
                        st_q  <= S_REC;
                    end else cnt_q <= cnt_nx;
                end
                S_REC: if (tick) begin
                    if (cnt_nx == t_q[P_REC]) begin
                        cnt_q <= '0;
                        st_q  <= S_IDLE;
                        done  <= 1'b1;
                    end else cnt_q <= cnt_nx;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assert_drive_in_op_R5: assert property (@(posedge clk) disable iff (rst)
        drive_low |-> busy);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(op_q) && $stable(t_q)));
    assert_pres_code_R7: assert property (@(posedge clk) disable iff (rst)
        pres != 2'd3);
endmodule

// File: rtl/owb_slot_master.sv
module owb_slot_master
    import owb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          us_tick,
    input  logic          cfg_we,
    input  logic          cfg_speed,
    input  logic [3:0]    cfg_sel,
    input  logic [TW-1:0] cfg_val,
    output logic [TW-1:0] cfg_rd,
    output logic          cfg_err,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          speed,
    output logic          busy,
    output logic          done,
    output logic          bit_out,
    output logic [1:0]    pres,
    output logic          drive_low,
    input  logic          bus_in
);
    tarr_t set_reg, set_od;

    owb_timing_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .spd     (cfg_speed),
        .sel     (cfg_sel),
        .val     (cfg_val),
        .rd      (cfg_rd),
        .err     (cfg_err),
        .set_reg (set_reg),
        .set_od  (set_od)
    );

    owb_slot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (us_tick),
        .start     (start),
        .op_i      (op),
        .spd_i     (speed),
        .set_reg   (set_reg),
        .set_od    (set_od),
        .bus_in    (bus_in),
        .busy      (busy),
        .done      (done),
        .bit_q     (bit_out),
        .pres      (pres),
        .drive_low (drive_low)
    );
endmodule

// File: tb/sim_owb_slot_master.sv
module sim_owb_slot_master;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1, us_tick = 1'b1;
    logic       cfg_we = 1'b0, cfg_speed = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [9:0] cfg_val = '0, cfg_rd;
    logic       cfg_err, start = 1'b0, speed = 1'b0;
    logic [1:0] op = '0, pres;
    logic       busy, done, bit_out, drive_low, bus_in;
    logic       dev_lvl = 1'b1;

    assign bus_in = ~drive_low & dev_lvl;

    int nchk = 0, nfail = 0;

    owb_slot_master u0 (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .cfg_we(cfg_we), .cfg_speed(cfg_speed), .cfg_sel(cfg_sel),
        .cfg_val(cfg_val), .cfg_rd(cfg_rd), .cfg_err(cfg_err),
        .start(start), .op(op), .speed(speed), .busy(busy), .done(done),
        .bit_out(bit_out), .pres(pres), .drive_low(drive_low), .bus_in(bus_in)
    );

    // {speed, select, value, expected error, expected readback}
    localparam int NV = 16;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 4'd0,  10'd100, 1'b0, 10'd100},  // R2 slot accepted
        {1'b0, 4'd0,  10'd120, 1'b1, 10'd100},  // R2 at upper bound
        {1'b0, 4'd0,  10'd59,  1'b1, 10'd100},  // R2 below lower bound
        {1'b0, 4'd2,  10'd15,  1'b1, 10'd1},    // R2 one-low bound
        {1'b0, 4'd2,  10'd14,  1'b0, 10'd14},   // R2
        {1'b0, 4'd5,  10'd15,  1'b1, 10'd15},   // R3 regular sample
        {1'b1, 4'd5,  10'd2,   1'b1, 10'd2},    // R3 overdrive sample
        {1'b1, 4'd6,  10'd80,  1'b1, 10'd48},   // R2 od reset-low bound
        {1'b1, 4'd6,  10'd79,  1'b0, 10'd79},   // R2
        {1'b0, 4'd4,  10'd960, 1'b1, 10'd15},   // R4 unbounded cap
        {1'b0, 4'd4,  10'd959, 1'b0, 10'd959},  // R4
        {1'b0, 4'd8,  10'd240, 1'b1, 10'd60},   // R2 presence-low bound
        {1'b1, 4'd0,  10'd16,  1'b1, 10'd11},   // R2 od slot bound
        {1'b1, 4'd0,  10'd6,   1'b0, 10'd6},    // R2 od slot low edge
        {1'b0, 4'd3,  10'd0,   1'b0, 10'd0},    // R2 release zero
        {1'b0, 4'd11, 10'd5,   1'b1, 10'd0}     // R2 unknown select
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic s, input logic [3:0] sel, input logic [9:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_speed = s; cfg_sel = sel; cfg_val = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic peek(input logic s, input logic [3:0] sel, output int v);
        @(negedge clk);
        cfg_speed = s; cfg_sel = sel;
        #1 v = int'(cfg_rd);
    endtask

    task automatic run_op(input logic [1:0] o, input logic s, output int cyc, output int lowc);
        @(negedge clk);
        start = 1'b1; op = o; speed = s;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        lowc = drive_low ? 1 : 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (drive_low) lowc++;
        end
    endtask

    task automatic dev_pulse(input int dly, input int wid);
        @(negedge drive_low);
        repeat (dly) @(negedge clk);
        dev_lvl = 1'b0;
        repeat (wid) @(negedge clk);
        dev_lvl = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int cyc, lowc, v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 drive_low after reset", drive_low, 0);
        chk("R1 bit_out after reset", bit_out, 0);
        chk("R1 pres after reset", pres, 0);
        chk("R1 cfg_err after reset", cfg_err, 0);

        for (int i = 0; i < NV; i++) begin
            cfg_write(VEC[i][25], VEC[i][24:21], VEC[i][20:11]);
            chk($sformatf("R2 vector %0d err", i), cfg_err, VEC[i][10]);
            chk($sformatf("R2 vector %0d readback", i), cfg_rd, VEC[i][9:0]);
        end

        do_reset();
        peek(1'b0, 4'd0, v);  chk("R1 regular slot default", v, 60);
        peek(1'b0, 4'd7, v);  chk("R1 regular reset-high default", v, 480);
        peek(1'b0, 4'd4, v);  chk("R1 regular recovery default", v, 15);
        peek(1'b1, 4'd0, v);  chk("R1 overdrive slot default", v, 11);
        peek(1'b1, 4'd9, v);  chk("R1 overdrive presence-high default", v, 2);
        peek(1'b1, 4'd6, v);  chk("R1 overdrive reset-low default", v, 48);

        run_op(2'd1, 1'b0, cyc, lowc);
        chk("R5 regular write0 done", cyc, 75);
        chk("R5 regular write0 low", lowc, 60);
        run_op(2'd2, 1'b0, cyc, lowc);
        chk("R5 regular write1 done", cyc, 75);
        chk("R5 regular write1 low", lowc, 1);
        run_op(2'd1, 1'b1, cyc, lowc);
        chk("R8 overdrive write0 done", cyc, 12);
        chk("R8 overdrive write0 low", lowc, 6);

        dev_lvl = 1'b1;
        run_op(2'd3, 1'b0, cyc, lowc);
        chk("R6 regular read done", cyc, 75);
        chk("R6 read low", lowc, 1);
        chk("R6 read high bit", bit_out, 1);
        dev_lvl = 1'b0;
        run_op(2'd3, 1'b1, cyc, lowc);
        dev_lvl = 1'b1;
        chk("R6 overdrive read done", cyc, 12);
        chk("R6 read low bit", bit_out, 0);

        fork
            run_op(2'd0, 1'b0, cyc, lowc);
            dev_pulse(70, 100);
        join
        chk("R7 regular reset done", cyc, 975);
        chk("R7 regular reset low", lowc, 480);
        chk("R7 device present", pres, 0);
        run_op(2'd0, 1'b0, cyc, lowc);
        chk("R7 no device", pres, 1);
        fork
            run_op(2'd0, 1'b1, cyc, lowc);
            dev_pulse(4, 3);
        join
        chk("R7 overdrive reset done", cyc, 97);
        chk("R7 overdrive present", pres, 0);
        dev_lvl = 1'b0;
        run_op(2'd0, 1'b1, cyc, lowc);
        dev_lvl = 1'b1;
        chk("R7 wired wrong", pres, 2);

        cfg_write(1'b0, 4'd0, 10'd100);
        run_op(2'd2, 1'b0, cyc, lowc);
        chk("R8 programmed slot done", cyc, 115);

        // R9: start during an overdrive write1 is ignored
        @(negedge clk);
        start = 1'b1; op = 2'd2; speed = 1'b1;
        @(negedge clk);
        op = 2'd0; speed = 1'b0;
        cyc = 0; lowc = drive_low ? 1 : 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (drive_low) lowc++;
            start = (cyc == 3);
        end
        start = 1'b0;
        chk("R9 ignored start done", cyc, 12);
        chk("R9 ignored start low", lowc, 1);
        chk("R9 busy during done", busy, 0);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
        chk("R9 no restart", busy, 0);

        summary();
        $finish;
    end
endmodule